// File: doc/BRIEF.md
# Dual-Line Instruction Prefetch Queue

This block sits between a line-wide instruction memory read port and the first decode stage. It holds two line buffers that work in ping-pong fashion. Whenever one is empty, it asks memory for the next sequential line on its own initiative. It does not wait for the decoder to ask. The decoder sees a small window of bytes that starts at the current fetch pointer. That window may run from the end of one buffer into the start of the other. Each cycle the decoder reports how many of those bytes it has taken.

A redirect from branch resolution discards every buffered byte and restarts fetching at the target. Fetching begins with the line that holds the target, and the window begins at the target's offset within that line. A request can still be in flight when a redirect arrives. A single epoch bit marks such a request as stale, and its returning line is thrown away.

Top module: `ifetch_pingpong_queue`

## Requirements
- R1: After synchronous reset `win_count` is 0 and the unit requests the line at address 0 (`fetch_req_valid`=1, `fetch_req_addr`=0).
- R2: Every memory request is line-aligned, so `fetch_req_addr` bits [3:0] are 0. At most one request is outstanding at a time. An unaccepted request keeps its valid and its address until it is accepted, unless a redirect arrives.
- R3: After a line fills the current buffer, the next sequential line is requested for the other buffer while the decoder consumes nothing.
- R4: Byte i of the window, `win_bytes[8i+7:8i]`, equals the memory byte at `win_addr+i` for every i below `win_count`. Byte k of a line arrives on `fill_data[8k+7:8k]`.
- R5: `win_count` = min(3, bytes buffered from the pointer onward). The window straddles both buffers when the second one is full, so offsets 14 and 15 still give a count of 3.
- R6: When the current buffer runs out and the other buffer is empty, `win_count` is 0 (stall). With the other buffer empty, offset 14 gives 2 and offset 15 gives 1.
- R7: `take_count` (0 up to `win_count`) advances `win_addr` by that many bytes. A buffer that has been fully consumed is released, and the line after the one held in the other buffer is requested for it.
- R8: `redir_valid` empties both buffers. In the next cycle `win_count` is 0 and `win_addr` equals the target. The line holding the target is fetched. `take_count` is ignored in a redirect cycle.
- R9: A line that returns for a request made before a redirect is discarded. This holds after several redirects, and also when the line arrives in the same cycle as the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redir_valid | input | 1 | Redirect from branch resolution |
| redir_addr | input | ADDR_W | Redirect target byte address |
| fetch_req_valid | output | 1 | Line read request valid |
| fetch_req_ready | input | 1 | Memory accepts the request |
| fetch_req_addr | output | ADDR_W | Line-aligned request address |
| fill_valid | input | 1 | Requested line returns this cycle |
| fill_data | input | LINE_BYTES*8 | Returned line, byte k at bits 8k+7:8k |
| win_bytes | output | WIN_BYTES*8 | Byte window at the fetch pointer |
| win_count | output | $clog2(WIN_BYTES+1) | Number of valid window bytes |
| win_addr | output | ADDR_W | Byte address of window byte 0 |
| take_count | input | $clog2(WIN_BYTES+1) | Bytes consumed by the decoder |

## Verification
The collision that matters is a redirect landing in the same cycle as a returning line. A close second is a redirect in the cycle a request is accepted. The bench provokes both. It counts down the latency of its memory model and fires the redirect exactly when the return is due. It also issues redirects back to back while a read is pending. The result is judged after the new target's line arrives. At that point the window address must equal the target, and every shown byte must match the memory contents at that address. Bytes from the stale line would differ.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int unsigned PFQ_ADDR_W     = 32;
    localparam int unsigned PFQ_LINE_BYTES = 16;
    localparam int unsigned PFQ_WIN_BYTES  = 3;

    // Tracking of the single in-flight line read
    typedef struct packed {
        logic busy;   // a read has been accepted and not yet answered
        logic epoch;  // epoch value when the read was accepted
        logic slot;   // buffer the line is destined for
    } pfq_pend_t;

    function automatic int unsigned pfq_min(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pfq_line_store.sv
module pfq_line_store #(
    parameter  int unsigned LINE_BYTES = 16,
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  logic                       wr_slot,
    input  logic [LINE_BITS-1:0]       wr_data,
    input  logic                       free_en,
    input  logic                       free_slot,
    output logic [1:0][LINE_BITS-1:0]  slot_data,
    output logic [1:0]                 slot_valid
);

    for (genvar s = 0; s < 2; s++) begin : g_slot
        logic                 vld_q;
        logic [LINE_BITS-1:0] dat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
            end else if (flush) begin
                vld_q <= 1'b0;
            end else if (wr_en && (wr_slot == 1'(s))) begin
                vld_q <= 1'b1;
            end else if (free_en && (free_slot == 1'(s))) begin
                vld_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && !flush && (wr_slot == 1'(s))) begin
                dat_q <= wr_data;
            end
        end

        assign slot_valid[s] = vld_q;
        assign slot_data[s]  = dat_q;
    end

    // A line is never written into the buffer that is being released
    AST_NO_WR_ON_FREE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && free_en && (wr_slot == free_slot))); // R7

endmodule

// File: rtl/pfq_window.sv
module pfq_window #(
    parameter  int unsigned LINE_BYTES = 16,
    parameter  int unsigned WIN_BYTES  = 3,
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8,
    localparam int unsigned OFS_W      = $clog2(LINE_BYTES),
    localparam int unsigned CNT_W      = $clog2(WIN_BYTES + 1),
    localparam int unsigned AVL_W      = OFS_W + 2
) (
    input  logic                       head,
    input  logic [OFS_W-1:0]           ptr,
    input  logic [1:0][LINE_BITS-1:0]  slot_data,
    input  logic [1:0]                 slot_valid,
    output logic [WIN_BYTES*8-1:0]     win_bytes,
    output logic [CNT_W-1:0]           win_count
);

    logic [AVL_W-1:0] avail;

    always_comb begin
        avail = '0;
        if (slot_valid[head]) begin
            avail = AVL_W'(LINE_BYTES) - AVL_W'(ptr);
            if (slot_valid[~head]) begin
                avail = avail + AVL_W'(LINE_BYTES);
            end
        end
        win_count = (avail >= AVL_W'(WIN_BYTES)) ? CNT_W'(WIN_BYTES) : CNT_W'(avail);
    end

    // One byte lane per window position; the carry bit picks the buffer
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_lane
        logic [OFS_W:0]   idx;
        logic             src;
        logic [OFS_W-1:0] lo;

        always_comb begin
            idx = {1'b0, ptr} + (OFS_W + 1)'(i);
            src = head ^ idx[OFS_W];
            lo  = idx[OFS_W-1:0];
            win_bytes[8*i +: 8] = slot_data[src][8*lo +: 8];
        end
    end

endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter  int unsigned ADDR_W     = 32,
    parameter  int unsigned LINE_BYTES = 16,
    localparam int unsigned OFS_W      = $clog2(LINE_BYTES),
    localparam int unsigned LN_W       = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redir_valid,
    input  logic [LN_W-1:0]   redir_line,
    input  logic              head,
    input  logic [1:0]        slot_valid,
    input  logic              req_ready,
    input  logic              fill_valid,
    output logic              req_valid,
    output logic [LN_W-1:0]   req_line,
    output logic              fill_wr,
    output logic              fill_slot
);

    pfq_pend_t       pend_q;
    logic            epoch_q;
    logic [LN_W-1:0] next_line_q;
    logic            tgt_slot;
    logic            hs;

    always_comb begin
        tgt_slot  = slot_valid[head] ? ~head : head;
        req_valid = !pend_q.busy && (slot_valid != 2'b11);
        hs        = req_valid && req_ready;
        fill_wr   = fill_valid && pend_q.busy && (pend_q.epoch == epoch_q) && !redir_valid;
        fill_slot = pend_q.slot;
    end

    assign req_line = next_line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            epoch_q     <= 1'b0;
            next_line_q <= '0;
        end else begin
            if (hs) begin
                pend_q <= '{busy: 1'b1, epoch: epoch_q, slot: tgt_slot};
            end else if (fill_valid) begin
                pend_q.busy <= 1'b0;
            end

            if (redir_valid) begin
                next_line_q <= redir_line;
                // Force a mismatch with the in-flight read, however many redirects follow
                if (hs) begin
                    epoch_q <= ~epoch_q;
                end else if (pend_q.busy) begin
                    epoch_q <= ~pend_q.epoch;
                end
            end else if (hs) begin
                next_line_q <= next_line_q + 1'b1;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready && !redir_valid |=> req_valid && $stable(req_line)); // R2

    AST_FILL_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> pend_q.busy); // R2

    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        fill_valid && pend_q.busy && (pend_q.epoch != epoch_q) |=> !slot_valid[$past(pend_q.slot)]); // R9

    AST_FILL_REDIR_DROPPED: assert property (@(posedge clk) disable iff (rst)
        fill_valid && redir_valid |=> (slot_valid == 2'b00)); // R9

endmodule

// File: rtl/ifetch_pingpong_queue.sv
module ifetch_pingpong_queue
    import pfq_pkg::*;
#(
    parameter  int unsigned ADDR_W     = PFQ_ADDR_W,
    parameter  int unsigned LINE_BYTES = PFQ_LINE_BYTES,
    parameter  int unsigned WIN_BYTES  = PFQ_WIN_BYTES,
    localparam int unsigned OFS_W      = $clog2(LINE_BYTES),
    localparam int unsigned LN_W       = ADDR_W - OFS_W,
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8,
    localparam int unsigned WIN_BITS   = WIN_BYTES * 8,
    localparam int unsigned CNT_W      = $clog2(WIN_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 redir_valid,
    input  logic [ADDR_W-1:0]    redir_addr,
    output logic                 fetch_req_valid,
    input  logic                 fetch_req_ready,
    output logic [ADDR_W-1:0]    fetch_req_addr,
    input  logic                 fill_valid,
    input  logic [LINE_BITS-1:0] fill_data,
    output logic [WIN_BITS-1:0]  win_bytes,
    output logic [CNT_W-1:0]     win_count,
    output logic [ADDR_W-1:0]    win_addr,
    input  logic [CNT_W-1:0]     take_count
);

    logic                       head_q;
    logic [OFS_W-1:0]           ptr_q;
    logic [LN_W-1:0]            line_q;

    logic [1:0]                 slot_valid;
    logic [1:0][LINE_BITS-1:0]  slot_data;
    logic                       fill_wr;
    logic                       fill_slot;
    logic [LN_W-1:0]            req_line;

    logic [CNT_W-1:0]           take_eff;
    logic [OFS_W:0]             sum;
    logic                       wrap;

    always_comb begin
        take_eff = redir_valid ? '0 : take_count;
        sum      = {1'b0, ptr_q} + (OFS_W + 1)'(take_eff);
        wrap     = sum[OFS_W];
    end

    // Pointer, current line and active buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= 1'b0;
            ptr_q  <= '0;
            line_q <= '0;
        end else if (redir_valid) begin
            ptr_q  <= redir_addr[OFS_W-1:0];
            line_q <= redir_addr[ADDR_W-1:OFS_W];
        end else if (take_eff != '0) begin
            ptr_q <= sum[OFS_W-1:0];
            if (wrap) begin
                head_q <= ~head_q;
                line_q <= line_q + 1'b1;
            end
        end
    end

    pfq_line_store #(
        .LINE_BYTES (LINE_BYTES)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (redir_valid),
        .wr_en      (fill_wr),
        .wr_slot    (fill_slot),
        .wr_data    (fill_data),
        .free_en    (wrap),
        .free_slot  (head_q),
        .slot_data  (slot_data),
        .slot_valid (slot_valid)
    );

    pfq_window #(
        .LINE_BYTES (LINE_BYTES),
        .WIN_BYTES  (WIN_BYTES)
    ) u_window (
        .head       (head_q),
        .ptr        (ptr_q),
        .slot_data  (slot_data),
        .slot_valid (slot_valid),
        .win_bytes  (win_bytes),
        .win_count  (win_count)
    );

    pfq_fetch_ctl #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .redir_valid(redir_valid),
        .redir_line (redir_addr[ADDR_W-1:OFS_W]),
        .head       (head_q),
        .slot_valid (slot_valid),
        .req_ready  (fetch_req_ready),
        .fill_valid (fill_valid),
        .req_valid  (fetch_req_valid),
        .req_line   (req_line),
        .fill_wr    (fill_wr),
        .fill_slot  (fill_slot)
    );

    assign fetch_req_addr = {req_line, {OFS_W{1'b0}}};
    assign win_addr       = {line_q, ptr_q};

    AST_TAKE_BOUND: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |-> take_count <= win_count); // R7

    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !redir_valid && (take_count != '0) |=> win_addr == $past(win_addr) + ADDR_W'($past(take_count))); // R7

    AST_REDIR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> win_count == '0); // R8

    AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> win_addr == $past(redir_addr)); // R8

    AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        slot_valid[~head_q] |-> slot_valid[head_q]); // R3

endmodule

// File: tb/ifetch_pingpong_queue_tb_top.sv
`timescale 1ns/1ps
module ifetch_pingpong_queue_tb_top;

    localparam int unsigned AW = 32;
    localparam int unsigned LB = 16;
    localparam int unsigned WB = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           redir_valid = 1'b0;
    logic [AW-1:0]  redir_addr = '0;
    logic           fetch_req_valid;
    logic           fetch_req_ready = 1'b0;
    logic [AW-1:0]  fetch_req_addr;
    logic           fill_valid = 1'b0;
    logic [LB*8-1:0] fill_data = '0;
    logic [WB*8-1:0] win_bytes;
    logic [1:0]     win_count;
    logic [AW-1:0]  win_addr;
    logic [1:0]     take_count = '0;

    always #4 clk = ~clk;

    ifetch_pingpong_queue dut_i (
        .clk             (clk),
        .rst             (rst),
        .redir_valid     (redir_valid),
        .redir_addr      (redir_addr),
        .fetch_req_valid (fetch_req_valid),
        .fetch_req_ready (fetch_req_ready),
        .fetch_req_addr  (fetch_req_addr),
        .fill_valid      (fill_valid),
        .fill_data       (fill_data),
        .win_bytes       (win_bytes),
        .win_count       (win_count),
        .win_addr        (win_addr),
        .take_count      (take_count)
    );

    int total = 0;
    int bad   = 0;

    // Drive controls
    bit          drv_redir = 0;
    logic [31:0] drv_target = '0;
    int          drv_take = 0;
    int          ready_pol = 0;   // 0 never, 1 always, 2 random
    int          fixed_dly = 1;   // negative: random latency
    // Memory model state
    bit          mem_busy = 0;
    logic [31:0] mem_addr = '0;
    int          mem_dly = 0;
    // Reference state
    logic [31:0] exp_pc = '0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    bit          watch_hit = 0;

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd37 + (a >> 7) * 32'd11 + 32'd5;
        return t[7:0];
    endfunction

    function automatic logic [LB*8-1:0] mline(input logic [31:0] base);
        logic [LB*8-1:0] d;
        for (int k = 0; k < LB; k++) d[8*k +: 8] = mbyte(base + 32'(k));
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look();
        #2;
    endtask

    // One clock cycle: drive at the falling edge, check settled outputs, predict
    task automatic step();
        @(negedge clk);
        fill_valid = 1'b0;
        if (mem_busy) begin
            if (mem_dly == 0) begin
                fill_valid = 1'b1;
                fill_data  = mline(mem_addr);
                mem_busy   = 0;
            end else begin
                mem_dly--;
            end
        end
        case (ready_pol)
            0: fetch_req_ready = 1'b0;
            1: fetch_req_ready = 1'b1;
            default: fetch_req_ready = ($urandom_range(0, 3) != 0);
        endcase
        redir_valid = drv_redir;
        redir_addr  = drv_target;
        take_count  = 2'(drv_take);
        #1;
        if (!rst) begin
            if (win_count != 0) begin
                chk(win_addr == exp_pc, "R8/R7 window address", win_addr, exp_pc);
                for (int i = 0; i < int'(win_count); i++)
                    chk(win_bytes[8*i +: 8] == mbyte(win_addr + 32'(i)), "R4 window byte",
                        32'(win_bytes[8*i +: 8]), 32'(mbyte(win_addr + 32'(i))));
            end
            if (fetch_req_valid && mem_busy)
                chk(0, "R2 second outstanding request", 32'd1, 32'd0);
            if (fetch_req_valid && fetch_req_ready) begin
                chk(fetch_req_addr[3:0] == 4'd0, "R2 aligned request", fetch_req_addr, fetch_req_addr & ~32'hF);
                mem_busy = 1;
                mem_addr = fetch_req_addr;
                mem_dly  = (fixed_dly < 0) ? int'($urandom_range(0, 3)) : fixed_dly;
                if (fetch_req_addr == watch_addr) watch_hit = 1;
            end
            if (drv_redir) exp_pc = drv_target;
            else           exp_pc = exp_pc + 32'(drv_take);
        end
        @(posedge clk);
    endtask

    task automatic take_once(input int n);
        drv_take = n;
        step();
        drv_take = 0;
        look();
    endtask

    task automatic redirect_once(input logic [31:0] t);
        drv_redir  = 1;
        drv_target = t;
        step();
        drv_redir  = 0;
        look();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog all requirements actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] tgt;
        void'($urandom(32'd4242));

        // R1: reset state
        rst = 1;
        ready_pol = 0;
        repeat (3) step();
        rst = 0;
        look();
        chk(win_count == 0, "R1 count after reset", 32'(win_count), 0);
        chk(fetch_req_valid == 1'b1, "R1 request after reset", 32'(fetch_req_valid), 1);
        chk(fetch_req_addr == 0, "R1 first request address", fetch_req_addr, 0);

        // R8: redirect to an unaligned target (line-0 read accepted in the same cycle)
        ready_pol  = 1;
        fixed_dly  = 1;
        watch_addr = 32'h210;
        redirect_once(32'h20D);
        chk(win_count == 0, "R8 empty after redirect", 32'(win_count), 0);
        chk(win_addr == 32'h20D, "R8 pointer at target", win_addr, 32'h20D);

        for (int n = 0; n < 30 && win_count != 3; n++) begin step(); look(); end
        chk(win_count == 3, "R5 full window at offset 13", 32'(win_count), 3);
        chk(win_addr == 32'h20D, "R8 window starts at target", win_addr, 32'h20D);

        // R3: next line requested without any consumption
        for (int n = 0; n < 30 && !(watch_hit && !mem_busy); n++) begin step(); look(); end
        chk(watch_hit, "R3 next line prefetched", 32'(watch_hit), 1);
        repeat (3) begin step(); look(); end
        ready_pol = 0;

        // R5: straddling window with both buffers full
        take_once(1);
        chk(win_count == 3, "R5 count at offset 14", 32'(win_count), 3);
        take_once(1);
        chk(win_count == 3, "R5 count at offset 15", 32'(win_count), 3);
        take_once(3);
        chk(win_addr == 32'h212, "R7 crossing into second buffer", win_addr, 32'h212);
        chk(win_count == 3, "R7 count after crossing", 32'(win_count), 3);
        chk(fetch_req_valid && fetch_req_addr == 32'h220, "R7 refill request for freed buffer",
            fetch_req_addr, 32'h220);

        // R6: drain with the other buffer empty
        repeat (4) take_once(3);
        chk(win_count == 2, "R6 count at offset 14 alone", 32'(win_count), 2);
        take_once(1);
        chk(win_count == 1, "R6 count at offset 15 alone", 32'(win_count), 1);
        take_once(1);
        chk(win_count == 0, "R6 stall when both empty", 32'(win_count), 0);
        repeat (3) begin step(); look(); end
        chk(win_count == 0, "R6 stall holds without memory", 32'(win_count), 0);

        ready_pol = 1;
        for (int n = 0; n < 20 && win_count == 0; n++) begin step(); look(); end
        chk(win_addr == 32'h220 && win_count != 0, "R6 resume after refill", win_addr, 32'h220);

        // R9: two redirects while a read is in flight
        fixed_dly = 3;
        for (int n = 0; n < 20 && !mem_busy; n++) begin step(); look(); end
        redirect_once(32'h400);
        redirect_once(32'h507);
        for (int n = 0; n < 40 && win_count == 0; n++) begin step(); look(); end
        chk(win_addr == 32'h507 && win_count != 0, "R9 stale line dropped after two redirects",
            win_addr, 32'h507);

        // R9: redirect in the same cycle as a returning line
        fixed_dly = -1;
        ready_pol = 2;
        for (int r = 0; r < 8; r++) begin
            for (int n = 0; n < 40 && !(mem_busy && mem_dly == 0); n++) begin
                drv_take = $urandom_range(0, int'(win_count));
                step();
                drv_take = 0;
                look();
            end
            tgt = $urandom_range(0, 4095);
            drv_take = $urandom_range(0, int'(win_count));  // R8: ignored in redirect cycle
            redirect_once(tgt);
            drv_take = 0;
            for (int n = 0; n < 40 && win_count == 0; n++) begin step(); look(); end
            chk(win_addr == tgt && win_count != 0, "R9 same-cycle fill and redirect", win_addr, tgt);
        end

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            drv_take = $urandom_range(0, int'(win_count));
            if ($urandom_range(0, 49) == 0) begin
                drv_redir  = 1;
                drv_target = $urandom_range(0, 4095);
            end
            step();
            drv_redir = 0;
            drv_take  = 0;
            look();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule